// File: doc/BRIEF.md
# Parallel camera frame capture

This block takes one frame from an 8-bit parallel image sensor and streams it into on-chip memory through a simple write port. The sensor drives a pixel clock, a line-valid strobe, a frame-valid strobe and a byte-wide data bus. None of these belong to the system clock domain. The block passes all of them through a synchroniser chain, detects the rising edges of the pixel clock by oversampling, and writes one byte per pixel-clock period while line-valid is high.

Software loads a row count and a buffer length, then pulses `start`. The block first waits until both frame-valid and line-valid are low, so a frame already in progress is not captured. It then stores bytes at consecutive addresses starting at zero. Capture ends when the configured number of lines has completed or when the buffer length is reached, whichever comes first; the second case can end capture in the middle of a line. A one-cycle `done` pulse marks the end, and `byte_count` holds the number of bytes actually written. The system clock must run at least four times faster than the pixel clock.

Top module: `cam_frame_grab`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are low and `byte_count` is zero.
- R2: A `start` pulse while idle latches `cfg_rows` and `cfg_buf_len`, clears `byte_count` and raises `busy` from the next cycle. A length above 2^ADDR_W is clamped to 2^ADDR_W. A `start` while `busy` is high is ignored and does not change the capture in progress.
- R3: After arming, no byte is taken until frame-valid and line-valid have both been seen low, so the rest of a frame already in progress is skipped.
- R4: While line-valid is high, exactly one byte is written for each rising edge of the pixel clock. No byte is written while line-valid is low.
- R5: Bytes are written with `mem_addr` 0, 1, 2, … in arrival order, and `mem_wdata` equals the byte on the bus at that pixel-clock rising edge.
- R6: Each falling edge of line-valid completes one line. When the number of completed lines equals the latched row count, capture ends and nothing more is written.
- R7: When the number of bytes written reaches the latched buffer length, capture ends at once, even in the middle of a line, and nothing more is written.
- R8: A latched row count of zero or a buffer length of zero ends capture with zero bytes, without waiting for any sensor activity.
- R9: `done` is high for exactly one cycle per capture, and `busy` is also high in that cycle. `busy` stays high from the cycle after arming until the `done` cycle and is low afterwards.
- R10: `byte_count` equals the number of bytes written so far, and it holds its final value until the next arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm a capture (used only while idle) |
| cfg_rows | input | ROW_W | Number of lines to capture |
| cfg_buf_len | input | ADDR_W+1 | Buffer length in bytes |
| cam_pclk | input | 1 | Sensor pixel clock (asynchronous) |
| cam_lv | input | 1 | Sensor line-valid strobe (asynchronous) |
| cam_fv | input | 1 | Sensor frame-valid strobe (asynchronous) |
| cam_data | input | DATA_W | Sensor pixel data bus (asynchronous) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | Capture armed or running |
| done | output | 1 | One-cycle end-of-capture pulse |
| byte_count | output | ADDR_W+1 | Bytes written by the current or last capture |

## Verification
The checker tests these properties on every cycle: `done` is a single-cycle pulse inside `busy`, writes happen only while `busy` is high, the byte count never goes past the latched length, the count changes only on a write, and an idle `start` always raises `busy`. Some behaviour can only be shown by the bench scenarios, which compare the captured memory image with a model of the sensor stream. These are the data order and address sequence, which of the two end conditions wins, the skipping of a frame already in progress, the gating by line-valid during pixel-clock activity between lines, and the ignoring of a second `start`.

// File: rtl/cam_grab_pkg.sv
package cam_grab_pkg;

    // Default geometry used by the top level parameters
    localparam int unsigned CAM_DATA_W_DEF  = 8;
    localparam int unsigned CAM_ADDR_W_DEF  = 12;
    localparam int unsigned CAM_ROW_W_DEF   = 10;
    localparam int unsigned CAM_SYNC_DEF    = 2;

    // Capture sequencer states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } grab_state_e;

    // Per-cycle sensor events, all in the system clock domain
    typedef struct packed {
        logic pclk_rise;   // pixel clock went low to high
        logic line_on;     // line-valid currently high
        logic line_end;    // line-valid went high to low
        logic frame_on;    // frame-valid currently high
    } cam_evt_t;

    // The sensor is between frames and between lines
    function automatic logic sensor_quiet(input cam_evt_t e);
        return !e.frame_on && !e.line_on;
    endfunction

    // A byte is taken on a pixel clock rise inside an active line
    function automatic logic sample_now(input cam_evt_t e);
        return e.pclk_rise && e.line_on;
    endfunction

    // State decode for the busy flag
    function automatic logic state_active(input grab_state_e s);
        return s != ST_IDLE;
    endfunction

endpackage

// File: rtl/cam_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Every bit goes through the same number of stages, so bits that
// move together at the input still line up at the output.
module cam_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg_q[s] <= '0;
                else     stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cam_event_det.sv
// Turns synchronised sensor levels into per-cycle events. The pixel
// clock is oversampled, so a rise is seen once per sensor period and
// the next rise needs the clock to have gone low again first.
module cam_event_det
    import cam_grab_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pclk_s,
    input  logic     lv_s,
    input  logic     fv_s,
    output cam_evt_t evt
);
    logic pclk_q;
    logic lv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q <= 1'b0;
            lv_q   <= 1'b0;
        end else begin
            pclk_q <= pclk_s;
            lv_q   <= lv_s;
        end
    end

    always_comb begin
        evt.pclk_rise = pclk_s & ~pclk_q;
        evt.line_on   = lv_s;
        evt.line_end  = lv_q & ~lv_s;
        evt.frame_on  = fv_s;
    end
endmodule

// File: rtl/cam_capture_ctrl.sv
// Capture sequencer: arming, line counting, byte limit and the
// registered memory write port.
module cam_capture_ctrl
    import cam_grab_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned ROW_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [ADDR_W:0]   cfg_buf_len,
    input  cam_evt_t          evt,
    input  logic [DATA_W-1:0] pix_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W:0]   byte_count,
    output logic [ADDR_W:0]   limit_o
);
    localparam int unsigned CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

    grab_state_e       state_q;
    logic [ROW_W-1:0]  rows_q;
    logic [ROW_W-1:0]  lines_q;
    logic [CNT_W-1:0]  lim_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic [CNT_W-1:0]  cnt_inc;
    logic [ROW_W-1:0]  lines_inc;
    logic [CNT_W-1:0]  lim_clamped;

    always_comb begin
        cnt_inc     = cnt_q + 1'b1;
        lines_inc   = lines_q + 1'b1;
        lim_clamped = (cfg_buf_len > DEPTH) ? DEPTH : cfg_buf_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rows_q  <= '0;
            lines_q <= '0;
            lim_q   <= '0;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rows_q  <= cfg_rows;
                        lim_q   <= lim_clamped;
                        cnt_q   <= '0;
                        lines_q <= '0;
                        state_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (sensor_quiet(evt)) begin
                        if (rows_q == '0 || lim_q == '0) state_q <= ST_DONE;
                        else                             state_q <= ST_CAPTURE;
                    end
                end
                ST_CAPTURE: begin
                    if (sample_now(evt)) begin
                        we_q    <= 1'b1;
                        addr_q  <= cnt_q[ADDR_W-1:0];
                        wdata_q <= pix_data;
                        cnt_q   <= cnt_inc;
                        if (cnt_inc == lim_q) state_q <= ST_DONE;
                    end else if (evt.line_end) begin
                        lines_q <= lines_inc;
                        if (lines_inc == rows_q) state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign busy       = state_active(state_q);
    assign done       = (state_q == ST_DONE);
    assign byte_count = cnt_q;
    assign limit_o    = lim_q;
endmodule

// File: rtl/cam_frame_grab.sv
module cam_frame_grab
    import cam_grab_pkg::*;
#(
    parameter int unsigned DATA_W      = CAM_DATA_W_DEF,
    parameter int unsigned ADDR_W      = CAM_ADDR_W_DEF,
    parameter int unsigned ROW_W       = CAM_ROW_W_DEF,
    parameter int unsigned SYNC_STAGES = CAM_SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [ADDR_W:0]   cfg_buf_len,
    input  logic              cam_pclk,
    input  logic              cam_lv,
    input  logic              cam_fv,
    input  logic [DATA_W-1:0] cam_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W:0]   byte_count
);
    localparam int unsigned CNT_W  = ADDR_W + 1;
    localparam int unsigned SYNC_W = DATA_W + 3;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              pclk_s;
    logic              lv_s;
    logic              fv_s;
    logic [DATA_W-1:0] data_s;
    cam_evt_t          evt;
    logic [CNT_W-1:0]  ctl_limit;

    // Data passes through the same chain as the strobes
    assign raw_bus = {cam_pclk, cam_lv, cam_fv, cam_data};

    cam_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    assign {pclk_s, lv_s, fv_s, data_s} = sync_bus;

    cam_event_det evt_i (
        .clk    (clk),
        .rst    (rst),
        .pclk_s (pclk_s),
        .lv_s   (lv_s),
        .fv_s   (fv_s),
        .evt    (evt)
    );

    cam_capture_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_rows    (cfg_rows),
        .cfg_buf_len (cfg_buf_len),
        .evt         (evt),
        .pix_data    (data_s),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .byte_count  (byte_count),
        .limit_o     (ctl_limit)
    );
endmodule

// File: rtl/cam_frame_grab_chk.sv
module cam_frame_grab_chk #(
    parameter int unsigned CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mem_we,
    input logic [CNT_W-1:0] byte_count,
    input logic [CNT_W-1:0] limit
);
    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done is raised only while busy
    a_r9_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R7: no write outside a capture
    a_r7_we_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R7: count never passes the latched limit
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        busy |-> (byte_count <= limit));

    // R10: count moves only with a write
    a_r10_count_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !mem_we) |-> $stable(byte_count));

    // R2: start while idle arms the block
    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

bind cam_frame_grab cam_frame_grab_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .byte_count (byte_count),
    .limit      (ctl_limit)
);

// File: tb/cam_frame_grab_tb_top.sv
`timescale 1ns/1ps
module cam_frame_grab_tb_top;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 12;
    localparam int ROW_W  = 10;
    localparam int CNT_W  = ADDR_W + 1;
    localparam int HALF_P = 4;   // system cycles per pixel clock phase

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ROW_W-1:0]  cfg_rows = '0;
    logic [CNT_W-1:0]  cfg_buf_len = '0;
    logic              cam_pclk = 1'b0;
    logic              cam_lv = 1'b0;
    logic              cam_fv = 1'b0;
    logic [DATA_W-1:0] cam_data = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              busy;
    logic              done;
    logic [CNT_W-1:0]  byte_count;

    always #5 clk = ~clk;

    cam_frame_grab #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .cfg_rows    (cfg_rows),
        .cfg_buf_len (cfg_buf_len),
        .cam_pclk    (cam_pclk),
        .cam_lv      (cam_lv),
        .cam_fv      (cam_fv),
        .cam_data    (cam_data),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .byte_count  (byte_count)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] frame_bytes [0:1023];
    int         frame_len = 0;
    int         cap_addr [0:1023];
    logic [7:0] cap_data [0:1023];
    int         wr_cnt = 0;
    int         done_cnt = 0;

    // Port monitor, sampled just after each active edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (done) done_cnt++;
            if (mem_we) begin
                if (wr_cnt < 1024) begin
                    cap_addr[wr_cnt] = int'(mem_addr);
                    cap_data[wr_cnt] = mem_wdata;
                end
                wr_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic int exp_bytes(input int rows, input int width, input int lim);
        int t;
        if (rows == 0 || lim == 0) return 0;
        t = rows * width;
        return (t < lim) ? t : lim;
    endfunction

    task automatic clear_mon();
        @(negedge clk);
        wr_cnt   = 0;
        done_cnt = 0;
    endtask

    task automatic arm(input int rows, input int lim);
        @(negedge clk);
        cfg_rows    = ROW_W'(rows);
        cfg_buf_len = CNT_W'(lim);
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic pclk_period(input logic [7:0] d);
        cam_data = d;
        cam_pclk = 1'b0;
        repeat (HALF_P) @(negedge clk);
        cam_pclk = 1'b1;
        repeat (HALF_P) @(negedge clk);
    endtask

    // One sensor frame; pixel clock also runs between lines with junk data
    task automatic send_frame(input int lines, input int width);
        frame_len = 0;
        cam_fv = 1'b1;
        pclk_period(8'h3C);
        pclk_period(8'hC3);
        for (int l = 0; l < lines; l++) begin
            cam_lv = 1'b1;
            for (int b = 0; b < width; b++) begin
                logic [7:0] v;
                v = 8'($urandom);
                frame_bytes[frame_len] = v;
                frame_len++;
                pclk_period(v);
            end
            cam_lv = 1'b0;
            pclk_period(8'hA5);
            pclk_period(8'h5A);
        end
        cam_fv = 1'b0;
        pclk_period(8'hFF);
        pclk_period(8'h00);
        cam_pclk = 1'b0;
    endtask

    task automatic finish_case(input string req, input int exp_n);
        int bad;
        int lim;
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        chk(wr_cnt == exp_n, req, wr_cnt, exp_n);
        chk(int'(byte_count) == exp_n, "R10 byte_count", int'(byte_count), exp_n);
        chk(busy == 1'b0, "R9 busy after done", int'(busy), 0);
        bad = 0;
        lim = (wr_cnt < exp_n) ? wr_cnt : exp_n;
        for (int i = 0; i < lim; i++) begin
            if (cap_addr[i] != i || cap_data[i] != frame_bytes[i]) bad++;
        end
        chk(bad == 0, "R5 address/data order", bad, 0);
    endtask

    task automatic run_case(input string req, input int rows, input int width,
                            input int lines, input int lim);
        clear_mon();
        arm(rows, lim);
        repeat (3) @(negedge clk);
        send_frame(lines, width);
        finish_case(req, exp_bytes(rows, width, lim));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(mem_we == 1'b0, "R1 mem_we", int'(mem_we), 0);
        chk(byte_count == '0, "R1 byte_count", int'(byte_count), 0);

        // R2: busy raised in the cycle after start
        clear_mon();
        arm(2, 100);
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        repeat (3) @(negedge clk);
        send_frame(2, 5);
        finish_case("R4 full capture count", 10);

        // R6: row count ends capture before the fourth line
        run_case("R6 row limit", 3, 5, 4, 100);

        // R7: buffer limit ends mid-line
        run_case("R7 mid-line limit", 3, 6, 3, 10);

        // R7: limit equal to the frame size
        run_case("R7 exact limit", 2, 6, 3, 12);

        // R8: zero rows and zero buffer length
        clear_mon();
        arm(0, 50);
        repeat (10) @(negedge clk);
        chk(done_cnt == 1, "R8 zero rows done", done_cnt, 1);
        chk(wr_cnt == 0, "R8 zero rows writes", wr_cnt, 0);
        clear_mon();
        arm(3, 0);
        repeat (10) @(negedge clk);
        chk(done_cnt == 1, "R8 zero length done", done_cnt, 1);
        chk(byte_count == '0, "R8 zero length count", int'(byte_count), 0);

        // R3: arm in the middle of a frame, only the next frame is taken
        clear_mon();
        fork
            send_frame(3, 4);
            begin
                repeat (60) @(negedge clk);
                arm(2, 100);
            end
        join
        chk(wr_cnt == 0, "R3 partial frame skipped", wr_cnt, 0);
        send_frame(3, 4);
        finish_case("R3 next frame captured", 8);

        // R2: second start while busy is ignored
        clear_mon();
        arm(2, 100);
        repeat (3) @(negedge clk);
        fork
            send_frame(3, 6);
            begin
                repeat (40) @(negedge clk);
                cfg_rows    = ROW_W'(1);
                cfg_buf_len = CNT_W'(1);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        finish_case("R2 start ignored while busy", 12);

        // Constrained random frames
        for (int k = 0; k < 12; k++) begin
            int r, w, l, lim;
            r   = int'($urandom_range(1, 4));
            w   = int'($urandom_range(1, 8));
            l   = r + int'($urandom_range(0, 1));
            lim = int'($urandom_range(1, 40));
            if (lim < r * w) run_case("R7 random limit", r, w, l, lim);
            else             run_case("R6 random rows", r, w, l, lim);
        end

        summary();
    end
endmodule